// File: doc/BRIEF.md
# Checksummed Register-Access Command Decoder

This block sits between a host byte stream and an on-chip register bus. The host sends five-byte command frames. Each frame opens with a fixed start byte (0x55) and carries a control byte with the transfer direction and the upper address bits, the low address byte, a data byte, and a trailing additive checksum. The decoder hunts for the start byte, gathers the rest of the frame and checks the checksum. A frame that passes starts exactly one read or one write on the register bus.

Every completed transaction is echoed back to the host as a five-byte frame with the same layout on an outgoing valid/ready stream. For a read, the echoed data byte is the value read from the bus. The last byte of the echo is flagged. While an echo is pending, the input side is closed to new bytes. A frame whose checksum fails produces no bus activity and no echo, and the decoder resumes hunting for the next start byte.

The control flow is one state machine with five states:
- `S_HUNT` waits for the start byte.
- `S_GATHER` collects the four remaining bytes and, on the checksum byte, goes to `S_ACCESS` (checksum matches) or back to `S_HUNT` (mismatch).
- `S_ACCESS` presents the address and pulses the write enable for writes, then goes to `S_FETCH`.
- `S_FETCH` latches the response data and launches the echo, then goes to `S_REPLY`.
- `S_REPLY` waits until the fifth echo byte is accepted, then returns to `S_HUNT`.

Top module: `regcmd_decoder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `reg_we` is 0.
- R2: Bytes received while hunting are discarded unless they equal 0x55. A 0x55 starts a frame, and the next four accepted bytes belong to that frame even if they equal 0x55.
- R3: The fifth byte must equal the 8-bit wrapping sum of the first four bytes. On a mismatch there is no `reg_we` pulse and no response, and the decoder hunts again.
- R4: Byte 2 bit 7 = 1 selects a write and 0 selects a read. The address is {byte2[5:0], byte3}, 14 bits. Byte 2 bit 6 does not affect the address.
- R5: A valid write frame produces exactly one single-cycle `reg_we` pulse, with `reg_addr` set to the frame address and `reg_wdata` set to byte 4.
- R6: A valid read frame produces no `reg_we` pulse, and its byte 4 is ignored. The address is held on `reg_addr` for the two cycles after the checksum byte is accepted, and `reg_rdata` is captured at the end of the second of those cycles.
- R7: Each valid frame is answered with the bytes 0x55, byte 2 unchanged, byte 3, the data byte, and the wrapping sum of those four. The data byte is the write data for a write and the captured read data for a read.
- R8: `out_last` is 1 on the fifth response byte only. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` stay unchanged.
- R9: `in_ready` is 0 from the cycle after the checksum byte is accepted until the fifth response byte has been accepted. In particular, it is never 1 while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Incoming command byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| out_data | output | 8 | Response byte |
| out_valid | output | 1 | Response byte present |
| out_last | output | 1 | Marks the fifth response byte |
| out_ready | input | 1 | Downstream accepts the response byte |
| reg_addr | output | 14 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | Register bus write enable, one-cycle pulse |
| reg_rdata | input | 8 | Register bus read data |

## Verification
The assertions check three things on every cycle:
- the write enable never lasts more than one cycle;
- the input side is closed while a response byte is offered;
- a stalled response byte and its last flag hold steady, and the last flag never appears without valid.

Only the bench scenarios can show that the bytes are right: the decoded address and direction, the echoed data (especially read data coming back from a registered bus model), the checksum of each response, the rejection of corrupted frames, and the recovery from junk bytes. For this, the bench sweeps all 64 upper-address values in both directions, under both a free-running and a stalling downstream.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_HI_W = 6;
    localparam int ADDR_W    = ADDR_HI_W + BYTE_W;
    localparam int FRAME_LEN = 5;
    localparam int POS_W     = $clog2(FRAME_LEN + 1);

    typedef enum logic [2:0] {
        S_HUNT,
        S_GATHER,
        S_ACCESS,
        S_FETCH,
        S_REPLY
    } state_t;
endpackage

// File: rtl/rcd_frame_capture.sv
module rcd_frame_capture import rcd_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic              en,
    input  logic [POS_W-1:0]  pos,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] ctl,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] dat,
    output logic [BYTE_W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
            lo  <= '0;
            dat <= '0;
            sum <= '0;
        end else if (first) begin
            sum <= din;
        end else if (en) begin
            sum <= sum + din;
            unique case (pos)
                POS_W'(1): ctl <= din;
                POS_W'(2): lo  <= din;
                POS_W'(3): dat <= din;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rcd_tx_emit.sv
module rcd_tx_emit import rcd_pkg::*; #(
    parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] b_ctl,
    input  logic [BYTE_W-1:0] b_lo,
    input  logic [BYTE_W-1:0] b_dat,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic              done
);
    localparam logic [POS_W-1:0] LAST_IDX = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0]  idx;
    logic              active;
    logic [BYTE_W-1:0] chk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active && out_ready) begin
            if (idx == LAST_IDX) active <= 1'b0;
            else                 idx    <= idx + 1'b1;
        end
    end

    assign chk = SYNC_BYTE + b_ctl + b_lo + b_dat;

    always_comb begin
        unique case (idx)
            POS_W'(0): out_data = SYNC_BYTE;
            POS_W'(1): out_data = b_ctl;
            POS_W'(2): out_data = b_lo;
            POS_W'(3): out_data = b_dat;
            default:   out_data = chk;
        endcase
    end

    assign out_valid = active;
    assign out_last  = active && (idx == LAST_IDX);
    assign done      = active && (idx == LAST_IDX) && out_ready;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder import rcd_pkg::*; #(
    parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [POS_W-1:0] CHK_POS = POS_W'(FRAME_LEN - 1);

    state_t            state, nxt;
    logic [POS_W-1:0]  cnt;
    logic              take, hit_sync, cap_en, chk_ok;
    logic              emit_go, emit_done;
    logic [BYTE_W-1:0] ctl, lo, dat, run_sum, resp_dat;

    assign in_ready = (state == S_HUNT) || (state == S_GATHER);
    assign take     = in_valid && in_ready;
    assign hit_sync = take && (state == S_HUNT) && (in_data == SYNC_BYTE);
    assign cap_en   = take && (state == S_GATHER) && (cnt != CHK_POS);
    assign chk_ok   = (in_data == run_sum);

    rcd_frame_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .first (hit_sync),
        .en    (cap_en),
        .pos   (cnt),
        .din   (in_data),
        .ctl   (ctl),
        .lo    (lo),
        .dat   (dat),
        .sum   (run_sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_HUNT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (hit_sync)    cnt <= POS_W'(1);
            else if (cap_en) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt     = state;
        reg_we  = 1'b0;
        emit_go = 1'b0;
        unique case (state)
            S_HUNT:   if (hit_sync) nxt = S_GATHER;
            S_GATHER: if (take && cnt == CHK_POS) nxt = chk_ok ? S_ACCESS : S_HUNT;
            S_ACCESS: begin
                reg_we = ctl[BYTE_W-1];
                nxt    = S_FETCH;
            end
            S_FETCH: begin
                emit_go = 1'b1;
                nxt     = S_REPLY;
            end
            S_REPLY:  if (emit_done) nxt = S_HUNT;
            default:  nxt = S_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              resp_dat <= '0;
        else if (state == S_FETCH) resp_dat <= ctl[BYTE_W-1] ? dat : reg_rdata;
    end

    assign reg_addr  = {ctl[ADDR_HI_W-1:0], lo};
    assign reg_wdata = dat;

    rcd_tx_emit #(.SYNC_BYTE(SYNC_BYTE)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (emit_go),
        .b_ctl     (ctl),
        .b_lo      (lo),
        .b_dat     (resp_dat),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_ready (out_ready),
        .done      (emit_done)
    );

    // R5
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R9
    input_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/regcmd_decoder_test.sv
`timescale 1ns/100ps
module regcmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;
    logic        out_valid, out_last;
    logic        out_ready = 1'b1;
    logic [13:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we;
    logic [7:0]  reg_rdata = '0;

    always #2.5 clk = ~clk;

    regcmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_last(out_last), .out_ready(out_ready), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    int nchk = 0, nfail = 0, cyc = 0, wcount = 0, rframes = 0, ridx = 0, viol = 0;
    bit fin = 0, rmode = 0;
    logic [13:0] waddr;
    logic [7:0]  wdata;
    logic [7:0]  rbuf [5];
    logic [4:0]  rlast;

    function automatic logic [7:0] mdl_rd(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h3C;
    endfunction

    // registered-read register bank model
    always @(posedge clk) reg_rdata <= mdl_rd(reg_addr);

    always @(negedge clk) begin
        bit rdy;
        cyc++;
        rdy = rmode ? (cyc % 3 != 0) : 1'b1;
        out_ready = rdy;
        if (rst_n) begin
            if (reg_we) begin wcount++; waddr = reg_addr; wdata = reg_wdata; end
            if (out_valid && in_ready) viol++;
            if (out_valid && rdy) begin
                rbuf[ridx] = out_data;
                rlast[ridx] = out_last;
                if (ridx == 4) begin ridx = 0; rframes++; end
                else ridx++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] c, input logic [7:0] l,
                             input logic [7:0] d, input bit bad);
        int w0 = wcount, f0 = rframes;
        logic [7:0] s, ed, es;
        logic [13:0] ea;
        s = 8'h55 + c + l + d;
        send_byte(8'h55); send_byte(c); send_byte(l); send_byte(d);
        send_byte(bad ? s + 8'h01 : s);
        if (bad) begin
            repeat (20) @(negedge clk);
            chk(rframes == f0, "R3 no response on bad checksum", rframes, f0);
            chk(wcount == w0, "R3 no write on bad checksum", wcount, w0);
        end else begin
            for (int t = 0; t < 200 && rframes == f0; t++) @(negedge clk);
            ea = {c[5:0], l};
            ed = c[7] ? d : mdl_rd(ea);
            es = 8'h55 + c + l + ed;
            chk(rframes == f0 + 1, "R7 response count", rframes, f0 + 1);
            chk(rbuf[0] == 8'h55, "R7 start byte", rbuf[0], 8'h55);
            chk(rbuf[1] == c, "R7 control echo", rbuf[1], c);
            chk(rbuf[2] == l, "R7 address echo", rbuf[2], l);
            chk(rbuf[3] == ed, c[7] ? "R7 write data echo" : "R6 read data echo", rbuf[3], ed);
            chk(rbuf[4] == es, "R7 response checksum", rbuf[4], es);
            chk(rlast == 5'b10000, "R8 last on fifth byte only", rlast, 5'b10000);
            if (c[7]) begin
                chk(wcount == w0 + 1, "R5 one write pulse", wcount, w0 + 1);
                chk(waddr == ea, "R4 write address", waddr, ea);
                chk(wdata == d, "R5 write data", wdata, d);
            end else begin
                chk(wcount == w0, "R6 read makes no write", wcount, w0);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!fin) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(reg_we == 1'b0, "R1 reset reg_we", reg_we, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_frame(8'h80, 8'h03, 8'h00, 0);           // R4 write to 0x0003
        chk(rbuf[4] == 8'hD8, "R7 example checksum", rbuf[4], 8'hD8);

        for (int m = 0; m < 2; m++) begin
            rmode = m[0];
            for (int i = 0; i < 64; i++) begin
                run_frame(8'h80 | 8'(i), 8'(i * 7 + 1), 8'(i * 13), 0);
                run_frame(8'(i), 8'(i * 11), ~8'(i), 0);   // R6 data byte ignored
            end
        end
        rmode = 0;

        run_frame(8'h81, 8'h22, 8'h55, 0);           // R2 sync value inside frame is data
        run_frame(8'hC5, 8'h9A, 8'h11, 0);           // R4 bit 6 ignored for address
        run_frame(8'h45, 8'h10, 8'h00, 0);           // R4 read with bit 6 set
        run_frame(8'h83, 8'h44, 8'h66, 1);           // R3 bad write
        run_frame(8'h03, 8'h44, 8'h66, 1);           // R3 bad read
        run_frame(8'h8F, 8'hF0, 8'hA5, 0);           // R3 resync after bad frame

        send_byte(8'h12); send_byte(8'hAA); send_byte(8'h00);   // R2 junk while hunting
        run_frame(8'hBF, 8'hFF, 8'h7E, 0);
        chk(waddr == 14'h3FFF, "R2 frame after junk address", waddr, 14'h3FFF);

        chk(viol == 0, "R9 in_ready low while response offered", viol, 0);
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 input reopens after response",
            {in_ready, out_valid}, 2'b10);

        fin = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule